// File: doc/BRIEF.md
# Command-Driven Serial Register Port

This block is the serial slave side of a converter's control logic. A host drives chip select, serial clock and serial data in, and reads serial data out. Every transfer opens with an 8-bit command byte that names a register and a direction. A data phase follows that moves 24 bits into or out of that register. A setup command stretches the data phase to 72 bits and loads three registers in one frame.

The register file holds a configuration word, a gain word and an offset word. These three are presented on parallel outputs to the rest of the converter. It also holds a conversion result, which the converter core loads through a parallel port with a strobe and which the serial side can only read. The serial pins are sampled with the system clock through a synchronizer. The port acts on the edges it detects, so the serial clock must be several times slower than the system clock.

Top module: `ssp_port`

## Requirements
- R1: After reset the port is in command mode, the configuration, gain, offset and conversion registers are all zero, and `sdo_oe_o` is low.
- R2: In command mode the first 8 bits clocked in, MSB first, form the command byte. Bit 7 is 1 for a read and 0 for a write, bits 6..3 must be zero, and bits 2..0 select the register: 1 configuration, 2 gain, 3 offset, 4 conversion, 5 setup (write only). Any other byte is invalid: it is discarded, the port stays in command mode, and the next 8 bits form a new command.
- R3: A valid non-setup command is followed by exactly 24 data clocks, after which the port is back in command mode without CS being released.
- R4: A write of configuration (0x01), gain (0x02) or offset (0x03) takes effect on the 24th data bit and appears on the matching parallel output.
- R5: A read (0x81, 0x82, 0x83, 0x84) returns the selected register MSB first. SDI is sampled on the rising SCLK edge, and SDO changes only after a falling SCLK edge.
- R6: A pulse on `conv_load_i` captures `conv_data_i` into the conversion register, and command 0x84 reads it back.
- R7: Write command 0x04 consumes 24 data bits and leaves the conversion register unchanged.
- R8: Setup command 0x05 takes 72 data bits as three words written in the order offset, gain, configuration. Each word is committed when its 24th bit arrives.
- R9: Releasing CS mid-transfer aborts it and returns the port to command mode. A word that has not received all 24 bits is not written.
- R10: `sdo_oe_o` is low whenever CS is released, so the pad driver leaves SDO high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the SDO pad driver |
| conv_load_i | input | 1 | Strobe loading the conversion register |
| conv_data_i | input | 24 | Conversion result from the converter core |
| cfg_o | output | 24 | Configuration register |
| gain_o | output | 24 | Gain register |
| offset_o | output | 24 | Offset register |

## Verification
The bench builds the port with its default parameters: 24-bit words, an 8-bit command, a three-word setup frame and a two-stage synchronizer. With these values the bench can reach the 72-clock setup frame and the commit point of each of its words. It can also reach an abort that falls between two setup words, an invalid command byte followed at once by a valid one in the same frame, and a back-to-back read. The serial clock runs at a twelfth of the system clock, so every detected edge lands well inside a half period.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CFG   = 3'd1,
    SEL_GAIN  = 3'd2,
    SEL_OFFS  = 3'd3,
    SEL_CONV  = 3'd4,
    SEL_SETUP = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic     valid;
    logic     rd;
    reg_sel_e sel;
  } cmd_t;

  // Setup frame word order: offset, gain, configuration
  function automatic reg_sel_e setup_word_sel(input logic [1:0] idx);
    case (idx)
      2'd0:    return SEL_OFFS;
      2'd1:    return SEL_GAIN;
      default: return SEL_CFG;
    endcase
  endfunction
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= RST_VAL;
        else         st_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= RST_VAL;
        else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ssp_cmd_decode.sv
module ssp_cmd_decode
  import ssp_pkg::*;
#(
  parameter int unsigned CMD_W = 8
) (
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_t             cmd_o
);
  localparam int unsigned PAD_W = CMD_W - 4;

  logic     rd;
  reg_sel_e sel;
  logic     pad_ok;

  assign rd     = cmd_i[CMD_W-1];
  assign sel    = reg_sel_e'(cmd_i[2:0]);
  assign pad_ok = (cmd_i[CMD_W-2:3] == PAD_W'(0));

  always_comb begin
    cmd_o.rd  = rd;
    cmd_o.sel = sel;
    unique case (sel)
      SEL_CFG, SEL_GAIN, SEL_OFFS, SEL_CONV: cmd_o.valid = pad_ok;
      SEL_SETUP:                             cmd_o.valid = pad_ok && !rd;
      default:                               cmd_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/ssp_regfile.sv
module ssp_regfile
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  reg_sel_e          wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              conv_ld_i,
  input  logic [DATA_W-1:0] conv_i,
  input  reg_sel_e          rsel_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] gain_o,
  output logic [DATA_W-1:0] offs_o,
  output logic [DATA_W-1:0] conv_o
);
  logic [DATA_W-1:0] cfg_q, gain_q, offs_q, conv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      gain_q <= '0;
      offs_q <= '0;
    end else if (we_i) begin
      case (wsel_i)
        SEL_CFG:  cfg_q  <= wdata_i;
        SEL_GAIN: gain_q <= wdata_i;
        SEL_OFFS: offs_q <= wdata_i;
        default:  ;  // conversion result is read-only
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        conv_q <= '0;
    else if (conv_ld_i) conv_q <= conv_i;

  always_comb begin
    case (rsel_i)
      SEL_CFG:  rdata_o = cfg_q;
      SEL_GAIN: rdata_o = gain_q;
      SEL_OFFS: rdata_o = offs_q;
      SEL_CONV: rdata_o = conv_q;
      default:  rdata_o = '0;
    endcase
  end

  assign cfg_o  = cfg_q;
  assign gain_o = gain_q;
  assign offs_o = offs_q;
  assign conv_o = conv_q;
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned CMD_W       = 8,
  parameter int unsigned SETUP_WORDS = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              conv_load_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0] gain_o,
  output logic [DATA_W-1:0] offset_o
);
  localparam int unsigned MAX_W = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int unsigned CNT_W = $clog2(MAX_W);
  localparam int unsigned WRD_W = 2;
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_W - 1);

  // pin synchronizer: {cs_n, sclk, sdi}
  logic [2:0] pins_s;
  logic       cs_s_n, sclk_s, sdi_s;

  ssp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, sdi_i}),
    .q_o    (pins_s)
  );
  assign {cs_s_n, sclk_s, sdi_s} = pins_s;

  logic sclk_prev_q;
  logic rise_evt, fall_evt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_s;

  assign rise_evt = !cs_s_n &&  sclk_s && !sclk_prev_q;
  assign fall_evt = !cs_s_n && !sclk_s &&  sclk_prev_q;

  // sequencer state
  logic              in_data_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [WRD_W-1:0]  word_cnt_q;
  cmd_t              cmd_q;
  logic [MAX_W-1:0]  rx_q;
  logic [MAX_W-1:0]  rx_next;
  logic [DATA_W-1:0] tx_q;
  logic              sdo_q;

  assign rx_next = {rx_q[MAX_W-2:0], sdi_s};

  cmd_t dec;
  ssp_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_i (rx_next[CMD_W-1:0]),
    .cmd_o (dec)
  );

  logic              is_setup;
  logic [WRD_W-1:0]  last_word;
  logic              word_done;
  logic              rf_we;
  reg_sel_e          rf_wsel;
  logic [DATA_W-1:0] rf_rdata;
  logic [DATA_W-1:0] conv_q;

  assign is_setup  = (cmd_q.sel == SEL_SETUP);
  assign last_word = is_setup ? WRD_W'(SETUP_WORDS - 1) : '0;
  assign word_done = rise_evt && in_data_q && (bit_cnt_q == LAST_DAT);
  assign rf_we     = word_done && !cmd_q.rd;
  assign rf_wsel   = is_setup ? setup_word_sel(word_cnt_q) : cmd_q.sel;

  ssp_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .wsel_i    (rf_wsel),
    .wdata_i   (rx_next[DATA_W-1:0]),
    .conv_ld_i (conv_load_i),
    .conv_i    (conv_data_i),
    .rsel_i    (dec.sel),
    .rdata_o   (rf_rdata),
    .cfg_o     (cfg_o),
    .gain_o    (gain_o),
    .offs_o    (offset_o),
    .conv_o    (conv_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_q  <= 1'b0;
      bit_cnt_q  <= '0;
      word_cnt_q <= '0;
      cmd_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
    end else if (cs_s_n) begin
      // abort: partial words are never committed
      in_data_q  <= 1'b0;
      bit_cnt_q  <= '0;
      word_cnt_q <= '0;
    end else if (rise_evt) begin
      rx_q <= rx_next;
      if (!in_data_q) begin
        if (bit_cnt_q == LAST_CMD) begin
          bit_cnt_q <= '0;
          if (dec.valid) begin
            in_data_q  <= 1'b1;
            cmd_q      <= dec;
            word_cnt_q <= '0;
            tx_q       <= rf_rdata;
          end
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end else if (bit_cnt_q == LAST_DAT) begin
        bit_cnt_q <= '0;
        if (word_cnt_q == last_word) in_data_q  <= 1'b0;
        else                         word_cnt_q <= word_cnt_q + 1'b1;
      end else begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end else if (fall_evt && in_data_q && cmd_q.rd) begin
      tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       sdo_q <= 1'b0;
    else if (fall_evt) sdo_q <= (in_data_q && cmd_q.rd) ? tx_q[DATA_W-1] : 1'b0;

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = !cs_s_n;
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              cs_s_n,
  input logic              conv_load_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              fall_evt,
  input logic              in_data_q,
  input logic [CNT_W-1:0]  bit_cnt_q,
  input logic [DATA_W-1:0] cfg_o,
  input logic [DATA_W-1:0] gain_o,
  input logic [DATA_W-1:0] offset_o,
  input logic [DATA_W-1:0] conv_q
);
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_data_q ? (32'(bit_cnt_q) < DATA_W) : (32'(bit_cnt_q) < CMD_W));

  a_r4_commit_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({cfg_o, gain_o, offset_o}) |-> $past(in_data_q));

  a_r5_sdo_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(fall_evt));

  a_r7_conv_only_by_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_load_i |=> $stable(conv_q));

  a_r9_abort_to_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_n |=> !in_data_q);

  a_r10_oe_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2)) |-> !sdo_oe_o);
endmodule

bind ssp_port ssp_port_chk #(.DATA_W(DATA_W), .CMD_W(CMD_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .cs_s_n      (cs_s_n),
  .conv_load_i (conv_load_i),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .fall_evt    (fall_evt),
  .in_data_q   (in_data_q),
  .bit_cnt_q   (bit_cnt_q),
  .cfg_o       (cfg_o),
  .gain_o      (gain_o),
  .offset_o    (offset_o),
  .conv_q      (conv_q)
);

// File: tb/ssp_port_tb_top.sv
`timescale 1ns/1ps
module ssp_port_tb_top;
  localparam int HP = 6;  // SCLK half period in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe;
  logic        conv_ld = 1'b0;
  logic [23:0] conv_d = '0;
  logic [23:0] cfg, gain, offs;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssp_port dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cs_ni       (cs_n),
    .sclk_i      (sclk),
    .sdi_i       (sdi),
    .sdo_o       (sdo),
    .sdo_oe_o    (sdo_oe),
    .conv_load_i (conv_ld),
    .conv_data_i (conv_d),
    .cfg_o       (cfg),
    .gain_o      (gain),
    .offset_o    (offs)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One CS-low frame: 8 command bits then nbits data bits taken from wd[71:...]
  // (left aligned). SDO samples land left aligned in rd.
  task automatic frame(input logic [7:0] cmd, input int nbits,
                       input logic [71:0] wd, output logic [71:0] rd);
    rd = '0;
    cs_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < 8 + nbits; i++) begin
      sdi = (i < 8) ? cmd[7-i] : wd[71-(i-8)];
      wait_clk(HP);
      if (i >= 8) rd[71-(i-8)] = sdo;
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
    end
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(4 * HP);
  endtask

  task automatic wr24(input logic [7:0] cmd, input logic [23:0] d);
    logic [71:0] rd;
    frame(cmd, 24, {d, 48'h0}, rd);
  endtask

  task automatic rd24(input logic [7:0] cmd, output logic [23:0] d);
    logic [71:0] rd;
    frame(cmd, 24, '0, rd);
    d = rd[71:48];
  endtask

  task automatic t_reset;
    chk("R1 cfg", 72'(cfg), 0);
    chk("R1 gain", 72'(gain), 0);
    chk("R1 offset", 72'(offs), 0);
    chk("R1 oe", 72'(sdo_oe), 0);
  endtask

  task automatic t_oe;
    cs_n = 1'b0;
    wait_clk(HP);
    chk("R10 oe while selected", 72'(sdo_oe), 1);
    cs_n = 1'b1;
    wait_clk(HP);
    chk("R10 oe released", 72'(sdo_oe), 0);
  endtask

  task automatic t_write_read;
    logic [23:0] r;
    wr24(8'h01, 24'hA50F3C);
    chk("R4 cfg_o", 72'(cfg), 72'h A50F3C);
    wr24(8'h02, 24'h812345);
    chk("R4 gain_o", 72'(gain), 72'h812345);
    wr24(8'h03, 24'hFEDCBA);
    chk("R4 offset_o", 72'(offs), 72'hFEDCBA);
    rd24(8'h81, r);
    chk("R5 read cfg", 72'(r), 72'hA50F3C);
    rd24(8'h82, r);
    chk("R5 read gain", 72'(r), 72'h812345);
    rd24(8'h83, r);
    chk("R5 read offset", 72'(r), 72'hFEDCBA);
  endtask

  task automatic t_back_to_back;
    logic [71:0] rd;
    // 0x81 + 24 bits then 0x82 + 24 bits without releasing CS
    frame(8'h81, 56, {24'h0, 8'h82, 40'h0}, rd);
    chk("R3 first word", 72'(rd[71:48]), 72'hA50F3C);
    chk("R3 second word after re-entering command mode", 72'(rd[39:16]), 72'h812345);
  endtask

  task automatic t_conv;
    logic [23:0] r;
    wait_clk(1);
    conv_d  = 24'h3C5A96;
    conv_ld = 1'b1;
    wait_clk(1);
    conv_ld = 1'b0;
    conv_d  = 24'h000000;
    rd24(8'h84, r);
    chk("R6 conversion read", 72'(r), 72'h3C5A96);
    wr24(8'h04, 24'h123456);
    rd24(8'h84, r);
    chk("R7 conversion unchanged by write", 72'(r), 72'h3C5A96);
    chk("R7 cfg untouched", 72'(cfg), 72'hA50F3C);
  endtask

  task automatic t_invalid;
    logic [71:0] rd;
    // 0xFF invalid, next byte 0x81 must be taken as a command
    frame(8'hFF, 32, {8'h81, 64'h0}, rd);
    chk("R2 command after invalid byte", 72'(rd[63:40]), 72'hA50F3C);
    // 0x85 (read setup) invalid; 0x09 (pad bit set) invalid
    frame(8'h85, 32, {8'h83, 64'h0}, rd);
    chk("R2 0x85 invalid", 72'(rd[63:40]), 72'hFEDCBA);
    frame(8'h09, 32, {8'h01, 24'h777777, 40'h0}, rd);
    chk("R2 0x09 invalid then write", 72'(cfg), 72'h777777);
  endtask

  task automatic t_setup;
    logic [71:0] rd;
    frame(8'h05, 72, {24'h111111, 24'h222222, 24'h333333}, rd);
    chk("R8 offset word 0", 72'(offs), 72'h111111);
    chk("R8 gain word 1", 72'(gain), 72'h222222);
    chk("R8 cfg word 2", 72'(cfg), 72'h333333);
  endtask

  task automatic t_abort;
    logic [71:0] rd;
    logic [23:0] r;
    frame(8'h01, 12, {24'hBADBAD, 48'h0}, rd);
    chk("R9 partial cfg not written", 72'(cfg), 72'h333333);
    rd24(8'h81, r);
    chk("R9 command mode after abort", 72'(r), 72'h333333);
    frame(8'h05, 40, {24'hAAAAAA, 24'hBBBBBB, 24'h0}, rd);
    chk("R9 setup word 0 kept", 72'(offs), 72'hAAAAAA);
    chk("R9 setup partial gain not written", 72'(gain), 72'h222222);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_oe();
    t_write_read();
    t_back_to_back();
    t_conv();
    t_invalid();
    t_setup();
    t_abort();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule